// File: doc/BRIEF.md
# Serial Display Link Writer

This block is a write-only register port that pushes command and pixel traffic to a serial display controller. The link has four wires: a serial clock, a serial data line, an active-low chip select and a command/data line. On that line, low marks a command and high marks data. Software hands the block a 16-bit word together with one of two single-cycle write strobes. The byte strobe either starts an 8-bit transfer or, when its select bit is set, only releases chip select. The word strobe always sends all 16 bits, always as data. A read of the status word returns the busy flag in its top bit.

The serial clock comes straight from the system clock and runs at half its rate, with no divider. Each serial bit takes two system clocks. Chip select and the command/data line are plain registered levels. They keep their value between transfers, so several bytes can share one chip-select window until software releases it.

The strobes are plain write enables. There is no valid/ready pairing and no back-pressure. The block never stalls a write. A transfer strobe that arrives while a transfer is still running drops the rest of that transfer and starts the new one. Software that needs every bit on the wire polls the busy flag before it writes.

Top module: `spi_disp_ser`

## Requirements
- R1: While reset is asserted and after it is released with no strobe, spi_cs_n is 1, cmd_n is 0, spi_sclk is 0 and rdata is all zero.
- R2: A byte strobe (wr8) with wdata[8]=0 drives spi_cs_n to 0 and copies wdata[9] to cmd_n from the next cycle. It then sends wdata[7:0] on spi_mosi, bit 7 first.
- R3: A byte strobe with wdata[8]=1 starts no transfer. It drives spi_cs_n to 1 and copies wdata[9] to cmd_n from the next cycle.
- R4: A word strobe (wr16) drives cmd_n to 1 and spi_cs_n to 0 from the next cycle. It then sends wdata[15:0], bit 15 first.
- R5: spi_sclk is 0 whenever the block is idle. During a transfer it is low in the first system clock and high in the second system clock of every bit. This gives exactly 8 high pulses for a byte and 16 for a word.
- R6: spi_mosi changes only on the clock edge that ends a high spi_sclk phase. It is therefore stable on every rising spi_sclk.
- R7: rdata[15] is 1 from the cycle after a transfer strobe for exactly 16 cycles (byte) or 32 cycles (word). rdata[14:0] always reads 0.
- R8: With no strobe, spi_cs_n and cmd_n hold their values, including after a transfer completes.
- R9: When wr8 and wr16 are asserted together, the word behaviour of R4 applies.
- R10: A transfer strobe during a busy transfer abandons the remaining bits. It restarts the timing of R7 with the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr8 | input | 1 | Byte write strobe, one cycle |
| wr16 | input | 1 | Word write strobe, one cycle |
| wdata | input | 16 | Write word: payload, select bit 8, command/data bit 9 |
| rdata | output | 16 | Status word, bit 15 = busy |
| cmd_n | output | 1 | Low = command, high = data |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_sclk | output | 1 | Serial clock, idles low |

## Verification
Byte transfers are sent with alternating and lopsided bit patterns and both command/data settings. These show whether the serial tap is bit 7 and whether cmd_n follows bit 9. Word transfers with payloads whose two halves differ show a wrong tap or a short count. Tests with both strobes set and with the select bit set show that word priority wins and that a release does not start a transfer. A restart in the middle of a byte, and a release in the middle of a byte, show whether the counter and shifter reload or continue.

// File: rtl/spi_disp_pkg.sv
package spi_disp_pkg;
  typedef enum logic {
    XFER_BYTE = 1'b0,
    XFER_WORD = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/spi_disp_ctl.sv
module spi_disp_ctl
  import spi_disp_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SEL_BIT = 8,
  parameter int CMD_BIT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr8,
  input  logic              wr16,
  input  logic [DATA_W-1:0] wdata,
  output logic              start,
  output xfer_mode_e        mode,
  output logic              cs_n,
  output logic              cmd_n
);
  // a byte write with the select bit set only releases chip select
  assign start = wr16 | (wr8 & ~wdata[SEL_BIT]);
  assign mode  = wr16 ? XFER_WORD : XFER_BYTE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_n  <= 1'b1;
      cmd_n <= 1'b0;
    end else if (wr16) begin
      cs_n  <= 1'b0;
      cmd_n <= 1'b1;
    end else if (wr8) begin
      cs_n  <= wdata[SEL_BIT];
      cmd_n <= wdata[CMD_BIT];
    end
  end
endmodule

// File: rtl/spi_disp_seq.sv
module spi_disp_seq
  import spi_disp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  xfer_mode_e mode_in,
  output xfer_mode_e mode_q,
  output logic       busy,
  output logic       sclk
);
  localparam int END_BYTE = 2 * BYTE_W;
  localparam int END_WORD = 2 * WORD_W;
  localparam int CNT_W    = $clog2(END_WORD + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = (mode_q == XFER_WORD) ? CNT_W'(END_WORD) : CNT_W'(END_BYTE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      mode_q <= XFER_BYTE;
    end else if (start) begin
      cnt    <= CNT_W'(1);
      mode_q <= mode_in;
    end else if (cnt == last) begin
      cnt <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign busy = (cnt != '0);
  // odd count = low phase, even count = high phase
  assign sclk = busy & ~cnt[0];
endmodule

// File: rtl/spi_disp_shift.sv
module spi_disp_shift
  import spi_disp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              shift_en,
  input  xfer_mode_e        mode_q,
  output logic              mosi
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n)         sh <= '0;
    else if (load)      sh <= load_data;
    else if (shift_en)  sh <= {sh[WORD_W-2:0], 1'b0};
  end

  generate
    if (BYTE_W == WORD_W) begin : g_same_tap
      assign mosi = sh[WORD_W-1];
    end else begin : g_two_taps
      assign mosi = (mode_q == XFER_WORD) ? sh[WORD_W-1] : sh[BYTE_W-1];
    end
  endgenerate
endmodule

// File: rtl/spi_disp_ser.sv
module spi_disp_ser
  import spi_disp_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int SEL_BIT = 8,
  parameter int CMD_BIT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr8,
  input  logic              wr16,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              cmd_n,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  output logic              spi_sclk
);
  logic       start;
  logic       busy;
  xfer_mode_e mode_req;
  xfer_mode_e mode_q;

  spi_disp_ctl #(.DATA_W(DATA_W), .SEL_BIT(SEL_BIT), .CMD_BIT(CMD_BIT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr8(wr8), .wr16(wr16), .wdata(wdata),
    .start(start), .mode(mode_req), .cs_n(spi_cs_n), .cmd_n(cmd_n)
  );

  spi_disp_seq #(.BYTE_W(BYTE_W), .WORD_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode_req),
    .mode_q(mode_q), .busy(busy), .sclk(spi_sclk)
  );

  spi_disp_shift #(.BYTE_W(BYTE_W), .WORD_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .load_data(wdata),
    .shift_en(spi_sclk), .mode_q(mode_q), .mosi(spi_mosi)
  );

  assign rdata = {busy, {(DATA_W-1){1'b0}}};
endmodule

// File: rtl/spi_disp_ser_chk.sv
module spi_disp_ser_chk #(
  parameter int DATA_W  = 16,
  parameter int SEL_BIT = 8,
  parameter int CMD_BIT = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr8,
  input logic              wr16,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              cmd_n,
  input logic              spi_cs_n,
  input logic              spi_mosi,
  input logic              spi_sclk
);
  // R5
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[DATA_W-1] |-> !spi_sclk);
  // R7
  status_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-2:0] == '0);
  // R4
  word_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr16 |=> (!spi_cs_n && cmd_n));
  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr8 && !wr16 && wdata[SEL_BIT]) |=> spi_cs_n);
  // R2
  byte_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr8 && !wr16 && !wdata[SEL_BIT]) |=> (!spi_cs_n && (cmd_n == $past(wdata[CMD_BIT]))));
  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr16 || (wr8 && !wdata[SEL_BIT])) |=> (rdata[DATA_W-1] && !spi_sclk));
  // R6
  mosi_stable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> $stable(spi_mosi));
  // R8
  hold_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr8 && !wr16) |=> ($stable(spi_cs_n) && $stable(cmd_n)));
endmodule

bind spi_disp_ser spi_disp_ser_chk #(.DATA_W(DATA_W), .SEL_BIT(SEL_BIT), .CMD_BIT(CMD_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr8(wr8), .wr16(wr16), .wdata(wdata), .rdata(rdata),
  .cmd_n(cmd_n), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_sclk(spi_sclk)
);

// File: tb/spi_disp_ser_bench.sv
`timescale 1ns/1ps
module spi_disp_ser_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr8 = 1'b0;
  logic        wr16 = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        cmd_n, spi_cs_n, spi_mosi, spi_sclk;

  int checks = 0;
  int failures = 0;
  bit exp_q[$];
  string cur_req = "R2";

  spi_disp_ser u_spi_disp_ser (
    .clk(clk), .rst_n(rst_n), .wr8(wr8), .wr16(wr16), .wdata(wdata), .rdata(rdata),
    .cmd_n(cmd_n), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_sclk(spi_sclk)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected bit per high serial clock phase
  always @(negedge clk) begin
    if (rst_n && spi_sclk) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "extra sclk pulse", 32'(spi_sclk), 32'd0);
      end else begin
        automatic bit e = exp_q.pop_front();
        chk(spi_mosi == e, cur_req, "serial bit", 32'(spi_mosi), 32'(e));
      end
    end
  end

  // driver: one strobe cycle, pushes the expected bit stream
  task automatic strobe(input bit b8, input bit b16, input logic [15:0] d, input string req);
    @(negedge clk); #1;
    if (b16 || (b8 && !d[8])) begin
      exp_q.delete();
      cur_req = req;
      for (int i = (b16 ? 15 : 7); i >= 0; i--) exp_q.push_back(d[i]);
    end
    wr8 = b8; wr16 = b16; wdata = d;
    @(negedge clk); #1;
    wr8 = 1'b0; wr16 = 1'b0; wdata = '0;
  endtask

  task automatic wait_idle(input int exp_len, input string req);
    int n = 0;
    while (rdata[15] && n < 100) begin
      n++;
      if (rdata[14:0] != 0) chk(1'b0, "R7", "low status bits", 32'(rdata), 32'(16'h8000));
      @(negedge clk); #1;
    end
    if (exp_len >= 0) chk(n == exp_len, "R7", "busy length", 32'(n), 32'(exp_len));
    chk(exp_q.size() == 0, req, "bits left unsent", 32'(exp_q.size()), 32'd0);
    chk(!spi_sclk, "R5", "sclk idle", 32'(spi_sclk), 32'd0);
  endtask

  initial begin
    #400000;
    chk(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 under reset and after release
    chk(spi_cs_n && !cmd_n && !spi_sclk && rdata == 0, "R1", "reset state",
        {rdata, 12'd0, spi_cs_n, cmd_n, spi_sclk, 1'b0}, 32'h8);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !cmd_n && !spi_sclk && rdata == 0, "R1", "idle after reset",
        {rdata, 12'd0, spi_cs_n, cmd_n, spi_sclk, 1'b0}, 32'h8);

    // R2 command byte
    strobe(1, 0, 16'hF0A5, "R2");
    chk(!spi_cs_n && !cmd_n, "R2", "cs/cmd after command byte", {spi_cs_n, cmd_n}, 2'b00);
    chk(rdata == 16'h8000, "R7", "busy after strobe", 32'(rdata), 32'h8000);
    wait_idle(16, "R2");
    // R8 lines hold after completion
    chk(!spi_cs_n && !cmd_n, "R8", "hold after byte", {spi_cs_n, cmd_n}, 2'b00);

    // R2 data byte, lopsided pattern
    strobe(1, 0, 16'h0201, "R2");
    chk(!spi_cs_n && cmd_n, "R2", "cs/cmd after data byte", {spi_cs_n, cmd_n}, 2'b01);
    wait_idle(16, "R2");

    // R4 word with distinct halves
    strobe(0, 1, 16'hC33C, "R4");
    chk(!spi_cs_n && cmd_n, "R4", "cs/cmd after word", {spi_cs_n, cmd_n}, 2'b01);
    wait_idle(32, "R4");
    strobe(0, 1, 16'h00FF, "R4");
    wait_idle(32, "R4");

    // R3 release, no transfer
    strobe(1, 0, 16'h0100, "R3");
    chk(spi_cs_n && !cmd_n, "R3", "release cmd=0", {spi_cs_n, cmd_n}, 2'b10);
    chk(rdata == 0, "R3", "no busy on release", 32'(rdata), 32'd0);
    repeat (4) @(negedge clk); #1;
    chk(!spi_sclk && spi_cs_n, "R8", "idle hold after release", {spi_cs_n, spi_sclk}, 2'b10);
    strobe(1, 0, 16'h0355, "R3");
    chk(spi_cs_n && cmd_n, "R3", "release cmd=1", {spi_cs_n, cmd_n}, 2'b11);
    chk(rdata == 0, "R3", "no busy on release", 32'(rdata), 32'd0);

    // R9 both strobes, select bit set and command bit clear
    strobe(1, 1, 16'h01C3, "R9");
    chk(!spi_cs_n && cmd_n, "R9", "word wins cs/cmd", {spi_cs_n, cmd_n}, 2'b01);
    wait_idle(32, "R9");

    // R10 restart a byte with a word midway
    strobe(1, 0, 16'h00AA, "R10");
    repeat (5) @(negedge clk);
    strobe(0, 1, 16'h5AA5, "R10");
    wait_idle(32, "R10");

    // R10 restart a byte with a byte midway
    strobe(1, 0, 16'h00F0, "R10");
    repeat (3) @(negedge clk);
    strobe(1, 0, 16'h0233, "R10");
    wait_idle(16, "R10");

    // R3 release mid-transfer: shifting continues, line released
    strobe(1, 0, 16'h0096, "R3");
    repeat (3) @(negedge clk);
    strobe(1, 0, 16'h0300, "R3");
    chk(spi_cs_n && cmd_n, "R3", "release while busy", {spi_cs_n, cmd_n}, 2'b11);
    wait_idle(-1, "R3");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule